// File: doc/BRIEF.md
# Attribute-Typed Control Register Bank

A bank of 32-bit control and status registers in which every bit carries an access attribute fixed at elaboration. The attribute decides what a software read, a software write and a hardware event do to that bit. The supported kinds are:

- plain read/write
- write gated by an unlock bit
- write-one-to-clear event flags
- read-to-clear, with or without software write access
- live hardware status
- hardwired constants
- fields loaded once from an initialisation port
- zero-type bits
- reserved bits

Any upstream agent can drive the simple synchronous register bus, whether configuration writes, a slave management interface or a serial-memory loader.

The bus is word addressed: `bus_addr` selects a register index. A write changes only the bytes enabled by `bus_be`. A read strobe returns data on `bus_rdata` one cycle later, and any read side effect takes place on that same edge. Hardware raises event bits through `hw_set`, presents live status on `hw_stat`, and loads the initialisation fields through `init_load`/`init_data` until `init_done` closes that path. The current view of every register is exported on `reg_q`.

Top module: `attr_regbank`

## Requirements
- R1: Synchronous active-high reset returns every stored bit to its default and clears `bus_rdata`. The only non-zero default is register 0 = 0x0A5C0000 (initialisation field 0x5C, constant field 0xA).
- R2: `bus_rdata` is loaded on the edge where `bus_rd` is high, with the register's value before any side effect of that read. It is valid from the next cycle and holds until the next read.
- R3: Read/write fields (register 0 bits [7:0], register 2 bits [31:16], register 3 bit 0) take write data only in bytes whose `bus_be` bit is set. Byte k covers bits [8k+7:8k].
- R4: The constant field (register 0 bits [27:24] = 0xA) and the status field (register 1 bits [31:24], which reads `hw_stat` of the same position) ignore writes. The status field follows `hw_stat` as it changes.
- R5: The read-clear field (register 1 bits [15:8]) becomes zero after a read and ignores writes.
- R6: The read-clear-writable field (register 1 bits [23:16]) becomes zero after a read and is updated by writes. A write in the same cycle as a read to that register wins over the clear.
- R7: Write-one-to-clear bits (register 1 bits [7:0]) are set only by `hw_set`. A written one clears a bit, a written zero and a read leave it unchanged, and a set in the same cycle as a clearing write leaves the bit at one.
- R8: `hw_set` also sets read-clear and read-clear-writable bits. A set in the same cycle as a read wins over the clear, and the set value is seen by the next read.
- R9: The lock-gated field (register 0 bits [15:8]) accepts writes only while the unlock bit (register 3 bit 0) held one before the write. Otherwise the write leaves it unchanged.
- R10: The initialisation field (register 0 bits [23:16]) loads from `init_data` when `init_load` is high. Loads are refused from the cycle `init_done` is first seen until the next reset, and software writes never change it.
- R11: Zero-type bits (register 2 bits [15:0], register 3 bits [7:1]) and reserved bits (register 0 bits [31:28], register 3 bits [31:8]) read zero and ignore writes.
- R12: `reg_q` carries register r's read view in bits [32r+31:32r].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables for writes |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| hw_set | input | NUM_REGS*DATA_W | Per-bit hardware set events |
| hw_stat | input | NUM_REGS*DATA_W | Per-bit live hardware status |
| init_load | input | 1 | Initialisation load strobe |
| init_data | input | NUM_REGS*DATA_W | Initialisation values |
| init_done | input | 1 | Closes the initialisation path until reset |
| reg_q | output | NUM_REGS*DATA_W | Read view of all registers |

## Verification
Stored fields change on the edge that samples a write, `hw_set` or `init_load`, so they are visible on `reg_q` one cycle later. Read data appears on `bus_rdata` one cycle after `bus_rd` is sampled. The bench therefore drives every stimulus on a falling edge and samples on the falling edge that follows the rising edge of interest. Each read check thus sees exactly one register stage.

Same-cycle collisions need a second step. For a set racing a clear, or a read racing a write, the bench first checks the returned pre-side-effect value, then issues a further read to observe the state left behind.

// File: rtl/attr_regbank_pkg.sv
package attr_regbank_pkg;

  typedef enum logic [3:0] {
    FA_RSVD,
    FA_RW,
    FA_RO,
    FA_HWST,
    FA_RC,
    FA_RCW,
    FA_W1C,
    FA_LOCK,
    FA_HWINIT,
    FA_ZERO
  } fattr_e;

  // Attribute of bit b in register r; the layout repeats every four registers.
  function automatic fattr_e field_attr(int r, int b);
    fattr_e a;
    case (r % 4)
      0: begin
        if (b < 8)       a = FA_RW;
        else if (b < 16) a = FA_LOCK;
        else if (b < 24) a = FA_HWINIT;
        else if (b < 28) a = FA_RO;
        else             a = FA_RSVD;
      end
      1: begin
        if (b < 8)       a = FA_W1C;
        else if (b < 16) a = FA_RC;
        else if (b < 24) a = FA_RCW;
        else             a = FA_HWST;
      end
      2: begin
        if (b < 16) a = FA_ZERO;
        else        a = FA_RW;
      end
      default: begin
        if (b == 0)     a = FA_RW;
        else if (b < 8) a = FA_ZERO;
        else            a = FA_RSVD;
      end
    endcase
    return a;
  endfunction

  // Reset default (and hardwired value for constant bits).
  function automatic logic field_rst(int r, int b);
    logic [31:0] v;
    v = ((r % 4) == 0) ? 32'h0A5C_0000 : 32'h0000_0000;
    return v[b % 32];
  endfunction

endpackage

// File: rtl/attr_initctl.sv
module attr_initctl (
  input  logic clk,
  input  logic rst,
  input  logic init_load,
  input  logic init_done,
  output logic init_acc
);

  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else if (init_done) done_q <= 1'b1;
  end

  assign init_acc = init_load && !done_q && !init_done;

endmodule

// File: rtl/attr_reg.sv
module attr_reg
  import attr_regbank_pkg::*;
#(
  parameter int REG_IDX = 0,
  parameter int DATA_W  = 32,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic              sel_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NBYTES-1:0] be,
  input  logic              unlock,
  input  logic              init_acc,
  input  logic [DATA_W-1:0] init_data,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_stat,
  output logic [DATA_W-1:0] rd_val
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam fattr_e ATTR = field_attr(REG_IDX, b);
    localparam logic   RV   = field_rst(REG_IDX, b);
    logic wr_b;
    assign wr_b = sel_wr && be[b/8];

    if (ATTR == FA_RW || ATTR == FA_LOCK) begin : g_rw
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else if (wr_b && (ATTR == FA_RW || unlock)) q <= wdata[b];
      end
      assign rd_val[b] = q;
    end else if (ATTR == FA_RC) begin : g_rc
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else if (hw_set[b]) q <= 1'b1;
        else if (sel_rd) q <= 1'b0;
      end
      assign rd_val[b] = q;
    end else if (ATTR == FA_RCW) begin : g_rcw
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else if (hw_set[b]) q <= 1'b1;
        else if (wr_b) q <= wdata[b];
        else if (sel_rd) q <= 1'b0;
      end
      assign rd_val[b] = q;
    end else if (ATTR == FA_W1C) begin : g_w1c
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else if (hw_set[b]) q <= 1'b1;
        else if (wr_b && wdata[b]) q <= 1'b0;
      end
      assign rd_val[b] = q;
    end else if (ATTR == FA_HWINIT) begin : g_hwinit
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else if (init_acc) q <= init_data[b];
      end
      assign rd_val[b] = q;
    end else if (ATTR == FA_HWST) begin : g_hwst
      assign rd_val[b] = hw_stat[b];
    end else if (ATTR == FA_RO) begin : g_ro
      assign rd_val[b] = RV;
    end else begin : g_zero
      assign rd_val[b] = 1'b0;
    end
  end

endmodule

// File: rtl/attr_rdmux.sv
module attr_rdmux #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_REGS*DATA_W-1:0] view,
  output logic [DATA_W-1:0]          rdata
);

  logic [DATA_W-1:0] sel_val;

  always_comb begin
    sel_val = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr == ADDR_W'(r)) sel_val = view[r*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= sel_val;
  end

endmodule

// File: rtl/attr_regbank.sv
module attr_regbank
  import attr_regbank_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int DATA_W     = 32,
  parameter int UNLOCK_REG = 3,
  parameter int UNLOCK_BIT = 0,
  localparam int ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int NBYTES    = DATA_W / 8,
  localparam int BANK_W    = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NBYTES-1:0] bus_be,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [BANK_W-1:0] hw_set,
  input  logic [BANK_W-1:0] hw_stat,
  input  logic              init_load,
  input  logic [BANK_W-1:0] init_data,
  input  logic              init_done,
  output logic [BANK_W-1:0] reg_q
);

  logic init_acc;
  logic unlock;

  assign unlock = reg_q[UNLOCK_REG*DATA_W + UNLOCK_BIT];

  attr_initctl u_init (
    .clk      (clk),
    .rst      (rst),
    .init_load(init_load),
    .init_done(init_done),
    .init_acc (init_acc)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic sel_wr, sel_rd;
    assign sel_wr = bus_wr && (bus_addr == ADDR_W'(r));
    assign sel_rd = bus_rd && (bus_addr == ADDR_W'(r));

    attr_reg #(
      .REG_IDX(r),
      .DATA_W (DATA_W)
    ) u_reg (
      .clk      (clk),
      .rst      (rst),
      .sel_wr   (sel_wr),
      .sel_rd   (sel_rd),
      .wdata    (bus_wdata),
      .be       (bus_be),
      .unlock   (unlock),
      .init_acc (init_acc),
      .init_data(init_data[r*DATA_W +: DATA_W]),
      .hw_set   (hw_set[r*DATA_W +: DATA_W]),
      .hw_stat  (hw_stat[r*DATA_W +: DATA_W]),
      .rd_val   (reg_q[r*DATA_W +: DATA_W])
    );
  end

  attr_rdmux #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_rdmux (
    .clk  (clk),
    .rst  (rst),
    .rd   (bus_rd),
    .addr (bus_addr),
    .view (reg_q),
    .rdata(bus_rdata)
  );

endmodule

// File: rtl/attr_regbank_chk.sv
module attr_regbank_chk #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int BANK_W  = NUM_REGS * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [BANK_W-1:0] hw_set,
  input logic              init_done,
  input logic [BANK_W-1:0] reg_q
);

  logic init_seen;

  always_ff @(posedge clk) begin
    if (rst) init_seen <= 1'b0;
    else if (init_done) init_seen <= 1'b1;
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R7
  w1c_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_set[39:32] != 8'h00) |=>
      ((reg_q[39:32] & $past(hw_set[39:32])) == $past(hw_set[39:32])));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(0) && !reg_q[96]) |=> $stable(reg_q[15:8]));

  // R10
  hwinit_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    init_seen |=> $stable(reg_q[23:16]));

  // R5
  rc_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(1) && hw_set[47:40] == 8'h00) |=>
      (reg_q[47:40] == 8'h00));

  // R11
  zero_rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(3)) |=> (bus_rdata[31:1] == 31'h0));

endmodule

bind attr_regbank attr_regbank_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/attr_regbank_test.sv
`timescale 1ns/1ps
module attr_regbank_test;

  localparam int NUM_REGS = 4;
  localparam int DATA_W   = 32;
  localparam int BANK_W   = NUM_REGS * DATA_W;

  typedef struct packed {
    logic        rd;
    logic [1:0]  a;
    logic [3:0]  be;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd0, 4'h0, 32'h0,         32'h0A33_0000, 4'd10}, // R10 loaded value
    '{1'b0, 2'd0, 4'hF, 32'hFFFF_FFFF, 32'h0,         4'd0},
    '{1'b1, 2'd0, 4'h0, 32'h0,         32'h0A33_00FF, 4'd9},  // R9 locked
    '{1'b0, 2'd3, 4'h1, 32'h0000_0001, 32'h0,         4'd0},
    '{1'b0, 2'd0, 4'h3, 32'h1234_5678, 32'h0,         4'd0},
    '{1'b1, 2'd0, 4'h0, 32'h0,         32'h0A33_5678, 4'd9},  // R9 unlocked
    '{1'b0, 2'd0, 4'h2, 32'hFFFF_AB00, 32'h0,         4'd0},
    '{1'b1, 2'd0, 4'h0, 32'h0,         32'h0A33_AB78, 4'd3},  // R3 byte 1 only
    '{1'b0, 2'd3, 4'hF, 32'h0,         32'h0,         4'd0},
    '{1'b0, 2'd0, 4'hF, 32'h0000_CD00, 32'h0,         4'd0},
    '{1'b1, 2'd0, 4'h0, 32'h0,         32'h0A33_AB00, 4'd9},  // R9 relocked
    '{1'b0, 2'd2, 4'hF, 32'hBEEF_FFFF, 32'h0,         4'd0},
    '{1'b1, 2'd2, 4'h0, 32'h0,         32'hBEEF_0000, 4'd11}, // R11 zero bits
    '{1'b0, 2'd2, 4'h4, 32'h1234_0000, 32'h0,         4'd0},
    '{1'b1, 2'd2, 4'h0, 32'h0,         32'hBE34_0000, 4'd3},  // R3 byte 2 only
    '{1'b0, 2'd3, 4'hF, 32'hFFFF_FFFF, 32'h0,         4'd0},
    '{1'b1, 2'd3, 4'h0, 32'h0,         32'h0000_0001, 4'd11}, // R11 reserved
    '{1'b0, 2'd3, 4'hF, 32'h0,         32'h0,         4'd0},
    '{1'b1, 2'd1, 4'h0, 32'h0,         32'h5A00_0000, 4'd4},  // R4 status
    '{1'b0, 2'd1, 4'hF, 32'hFFFF_FFFF, 32'h0,         4'd0},
    '{1'b1, 2'd1, 4'h0, 32'h0,         32'h5AFF_0000, 4'd6},  // R6 write
    '{1'b1, 2'd1, 4'h0, 32'h0,         32'h5A00_0000, 4'd6},  // R6 read clear
    '{1'b1, 2'd3, 4'h0, 32'h0,         32'h0,         4'd9}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [3:0]        bus_be = '0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic [BANK_W-1:0] hw_set = '0;
  logic [BANK_W-1:0] hw_stat = '0;
  logic              init_load = 1'b0;
  logic [BANK_W-1:0] init_data = '0;
  logic              init_done = 1'b0;
  logic [BANK_W-1:0] reg_q;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  attr_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .hw_set(hw_set), .hw_stat(hw_stat),
    .init_load(init_load), .init_data(init_data), .init_done(init_done),
    .reg_q(reg_q)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_set(int bitpos);
    @(negedge clk);
    hw_set[bitpos] = 1'b1;
    @(negedge clk);
    hw_set = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 reg0", reg_q[31:0], 32'h0A5C_0000);
    check("R1 reg2", reg_q[95:64], 32'h0);

    hw_stat[63:56] = 8'h5A;
    @(negedge clk);
    init_data[23:16] = 8'h33; init_load = 1'b1;
    @(negedge clk);
    init_load = 1'b0; init_done = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].rd) bus_read(VEC[i].a, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].rq, i));
      else           bus_write(VEC[i].a, VEC[i].d, VEC[i].be);
    end

    // R7 event flags
    @(negedge clk);
    hw_set[32] = 1'b1; hw_set[35] = 1'b1;
    @(negedge clk);
    hw_set = '0;
    bus_read(2'd1, 32'h5A00_0009, "R7 set");
    bus_read(2'd1, 32'h5A00_0009, "R7 read keeps");
    bus_write(2'd1, 32'h0000_0001, 4'h1);
    check("R2 rdata held", bus_rdata, 32'h5A00_0009);
    bus_read(2'd1, 32'h5A00_0008, "R7 one clears");
    bus_write(2'd1, 32'h0, 4'hF);
    bus_read(2'd1, 32'h5A00_0008, "R7 zero ignored");

    // R7 set beats clear
    @(negedge clk);
    hw_set[35] = 1'b1;
    bus_addr = 2'd1; bus_wdata = 32'h8; bus_be = 4'h1; bus_wr = 1'b1;
    @(negedge clk);
    hw_set = '0; bus_wr = 1'b0;
    bus_read(2'd1, 32'h5A00_0008, "R7 set wins");
    bus_write(2'd1, 32'h8, 4'h1);
    bus_read(2'd1, 32'h5A00_0000, "R7 cleared");

    // R5 read clear
    pulse_set(42);
    bus_read(2'd1, 32'h5A00_0400, "R5 set seen");
    bus_read(2'd1, 32'h5A00_0000, "R5 cleared by read");
    pulse_set(43);
    bus_write(2'd1, 32'h0000_0000, 4'hF);
    bus_read(2'd1, 32'h5A00_0800, "R5 write ignored");

    // R8 set during read
    @(negedge clk);
    hw_set[41] = 1'b1; bus_addr = 2'd1; bus_rd = 1'b1;
    @(negedge clk);
    hw_set = '0; bus_rd = 1'b0;
    check("R8 old value", bus_rdata, 32'h5A00_0000);
    bus_read(2'd1, 32'h5A00_0200, "R8 set survives read");
    bus_read(2'd1, 32'h5A00_0000, "R8 then cleared");

    // R6 write and read same cycle
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 32'h00AA_0000; bus_be = 4'h4;
    bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R6 old value", bus_rdata, 32'h5A00_0000);
    bus_read(2'd1, 32'h5AAA_0000, "R6 write wins");
    bus_read(2'd1, 32'h5A00_0000, "R6 cleared");

    pulse_set(48);
    bus_read(2'd1, 32'h5A01_0000, "R8 set rcw");

    // R4 live status
    hw_stat[63:56] = 8'hC3;
    bus_read(2'd1, 32'hC300_0000, "R4 status follows");
    bus_write(2'd1, 32'hFF00_0000, 4'h8);
    bus_read(2'd1, 32'hC300_0000, "R4 status write ignored");
    check("R12 reg1 view", reg_q[63:32], 32'hC300_0000);
    check("R12 reg2 view", reg_q[95:64], 32'hBE34_0000);

    // R10 late load refused
    @(negedge clk);
    init_data[23:16] = 8'h77; init_load = 1'b1;
    @(negedge clk);
    init_load = 1'b0;
    bus_read(2'd0, 32'h0A33_AB00, "R10 late load");

    // R1 reset
    @(negedge clk);
    rst = 1'b1; init_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 reg0 after reset", reg_q[31:0], 32'h0A5C_0000);
    check("R1 reg2 after reset", reg_q[95:64], 32'h0);
    check("R1 reg3 after reset", reg_q[127:96], 32'h0);

    // R10 load reopened after reset, then closed again
    @(negedge clk);
    init_data[23:16] = 8'h11; init_load = 1'b1;
    @(negedge clk);
    init_load = 1'b0;
    bus_read(2'd0, 32'h0A11_0000, "R10 load after reset");
    bus_write(2'd0, 32'h00FF_0000, 4'h4);
    bus_read(2'd0, 32'h0A11_0000, "R10 write ignored");
    @(negedge clk);
    init_done = 1'b1;
    @(negedge clk);
    init_data[23:16] = 8'h22; init_load = 1'b1;
    @(negedge clk);
    init_load = 1'b0;
    bus_read(2'd0, 32'h0A11_0000, "R10 closed");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule